// File: doc/BRIEF.md
# Cache-Side Coherence Protocol Engine

This block is the per-cache controller of a message-passing coherence scheme in which a cache pushes its modified data back to the home memory. It keeps a small direct-mapped array. Each entry holds a tag, one data word and a line state: Clean, Dirty, WritebackPending, FillPending, or absent. A processor port issues load, store, commit and reconcile operations. Each one is answered in the same cycle with either retire or stall. A stalled operation is simply reissued later.

Toward home, the engine emits fill requests, writebacks and purge notices through a one-entry output register with a valid/ready handshake. From home it accepts fill data, writeback acknowledges, flush acknowledges and purge requests. Voluntary triggers let the surrounding logic purge a clean line, write back a dirty one or prefetch an absent one.

Only one action commits per cycle. A home message wins over a processor operation, and a processor operation wins over a voluntary trigger. If the resident entry at an index holds a different tag, a load or store to the new address stalls until that entry has been evicted.

Top module: `coh_cache_engine`

## Requirements
- R1: After reset every line is absent, `outValid` is 0 and `inReady` is 1.
- R2: A load or store whose line is Clean or Dirty retires in the same cycle. A load returns the line's data on `procRdata`. A store writes `procWdata` and leaves the line Dirty. Operation codes: 0 load, 1 store, 2 commit, 3 reconcile. Every valid operation gets exactly one of retire or stall.
- R3: Any operation to a WritebackPending or FillPending line stalls and leaves the line unchanged.
- R4: A load or store to an absent line stalls. If the output register is empty and the index is free, the engine sends a fill request (type 0) for that address and the line becomes FillPending. If another tag occupies the index, the operation stalls, nothing is sent and nothing changes.
- R5: Commit retires on a Clean or absent line. On a Dirty line it stalls, sends a writeback (type 1) carrying the line's data, and moves the line to WritebackPending.
- R6: Reconcile retires on Clean, Dirty or absent lines and stalls on either pending state.
- R7: A fill message (home type 0) installs its data as Clean, whether the line was absent or FillPending.
- R8: A writeback acknowledge (home type 1) turns a WritebackPending line Clean and keeps its data. A flush acknowledge (home type 2) removes a WritebackPending line.
- R9: A purge request (home type 3) has three outcomes. On a Clean line it removes the line and sends a purge notice (type 2). On a Dirty line it sends a writeback with the data and moves to WritebackPending. On a pending or absent line it is ignored.
- R10: Voluntary triggers (kind 0 purge, 1 writeback, 2 prefetch) act as follows. Purge removes a Clean line and sends a purge notice. Writeback moves a Dirty line to WritebackPending with a writeback. Prefetch moves an absent, unoccupied line to FillPending with a fill request. A trigger that does not match the line's state does nothing.
- R11: A queued message keeps its fields until `outReady` is seen. While the register is full, no new message is loaded, `inReady` is 0, and an operation that would send a message stalls without changing state.
- R12: If a home message is accepted, a processor operation in the same cycle stalls with no effect. If a processor operation is present, a voluntary trigger in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| procValid | input | 1 | Processor operation present |
| procOp | input | 2 | Operation code |
| procAddr | input | ADDR_W | Operation address |
| procWdata | input | DATA_W | Store data |
| procRetire | output | 1 | Operation completes this cycle |
| procStall | output | 1 | Operation must be reissued |
| procRdata | output | DATA_W | Load data |
| inValid | input | 1 | Home message present |
| inReady | output | 1 | Home message accepted |
| inType | input | 2 | Home message type |
| inAddr | input | ADDR_W | Home message address |
| inData | input | DATA_W | Home fill data |
| volValid | input | 1 | Voluntary trigger present |
| volKind | input | 2 | Trigger kind |
| volAddr | input | ADDR_W | Trigger address |
| outValid | output | 1 | Outgoing message queued |
| outReady | input | 1 | Network takes the queued message |
| outType | output | 2 | Outgoing message type |
| outAddr | output | ADDR_W | Outgoing message address |
| outData | output | DATA_W | Outgoing writeback data |

## Verification
The collision of interest is a home message and a processor operation arriving in the same cycle. The test case pairs a writeback acknowledge with a reconcile that would retire if it arrived alone. The reconcile must stall. A following load must then return the retained value from a now-Clean line, which proves the acknowledge took effect and the reconcile had no side effect.

A second collision pairs a commit on a Clean line with a voluntary purge of that same line. The commit must retire. The output register must stay empty, and the line must still serve a load.

// File: rtl/coh_cache_engine_pkg.sv
`timescale 1ns/1ps
package coh_cache_engine_pkg;
  typedef enum logic [2:0] {LS_ABSENT, LS_CLEAN, LS_DIRTY, LS_WBPEND, LS_FILLPEND} lineState_e;
  typedef enum logic [1:0] {OP_LOAD, OP_STORE, OP_COMMIT, OP_RECONCILE} procOp_e;
  typedef enum logic [1:0] {HM_FILL, HM_WBACK, HM_FLUSHACK, HM_PURGEREQ} homeMsg_e;
  typedef enum logic [1:0] {CM_FILLREQ, CM_WB, CM_PURGE, CM_SPARE} cacheMsg_e;
  typedef enum logic [1:0] {VK_PURGE, VK_WRITEBACK, VK_PREFETCH, VK_SPARE} volKind_e;
  typedef enum logic [1:0] {SRC_NONE, SRC_HOME, SRC_PROC, SRC_VOL} src_e;

  typedef struct packed {
    logic       wrEn;
    logic       setTag;
    logic       wrData;
    logic       dataFromHome;
    lineState_e newState;
    logic       sendEn;
    cacheMsg_e  sendType;
  } strobe_t;
endpackage

// File: rtl/coh_cache_datapath.sv
`timescale 1ns/1ps
module coh_cache_datapath
  import coh_cache_engine_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  src_e              srcSel,
  input  logic [ADDR_W-1:0] procAddr,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [ADDR_W-1:0] volAddr,
  input  logic [DATA_W-1:0] procWdata,
  input  logic [DATA_W-1:0] inData,
  input  strobe_t           strobe,
  output lineState_e        hitState,
  output logic              conflict,
  output logic [DATA_W-1:0] lineData,
  input  logic              outReady,
  output logic              outValid,
  output cacheMsg_e         outType,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  lineState_e        stateArr [LINES];
  logic [TAG_W-1:0]  tagArr   [LINES];
  logic [DATA_W-1:0] dataArr  [LINES];

  logic [ADDR_W-1:0] selAddr;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              present, tagMatch;

  always_comb begin
    case (srcSel)
      SRC_HOME: selAddr = inAddr;
      SRC_VOL:  selAddr = volAddr;
      default:  selAddr = procAddr;
    endcase
  end

  assign idx      = selAddr[IDX_W-1:0];
  assign tag      = selAddr[ADDR_W-1:IDX_W];
  assign present  = (stateArr[idx] != LS_ABSENT);
  assign tagMatch = (tagArr[idx] == tag);
  assign hitState = (present && tagMatch) ? stateArr[idx] : LS_ABSENT;
  assign conflict = present && !tagMatch;
  assign lineData = dataArr[idx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) stateArr[i] <= LS_ABSENT;
    end else if (strobe.wrEn) begin
      stateArr[idx] <= strobe.newState;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn && strobe.setTag) tagArr[idx] <= tag;
    if (strobe.wrEn && strobe.wrData)
      dataArr[idx] <= strobe.dataFromHome ? inData : procWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outType  <= CM_FILLREQ;
      outAddr  <= '0;
      outData  <= '0;
    end else if (strobe.sendEn) begin
      outValid <= 1'b1;
      outType  <= strobe.sendType;
      outAddr  <= selAddr;
      outData  <= dataArr[idx];
    end else if (outValid && outReady) begin
      outValid <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outType) && $stable(outAddr) && $stable(outData))); // R11
  AST_SEND_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sendEn |-> !outValid); // R11
  AST_FILLPEND_HAS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.newState == LS_FILLPEND) |-> (strobe.sendEn && strobe.sendType == CM_FILLREQ)); // R4
endmodule

// File: rtl/coh_cache_control.sv
`timescale 1ns/1ps
module coh_cache_control
  import coh_cache_engine_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procValid,
  input  procOp_e           procOp,
  input  logic              inValid,
  input  homeMsg_e          inType,
  input  logic              volValid,
  input  volKind_e          volKind,
  input  logic              slotFree,
  input  lineState_e        hitState,
  input  logic              conflict,
  input  logic [DATA_W-1:0] lineData,
  output src_e              srcSel,
  output strobe_t           strobe,
  output logic              procRetire,
  output logic              procStall,
  output logic [DATA_W-1:0] procRdata,
  output logic              inReady
);
  logic homeGo;
  logic freeIdx;

  assign inReady   = slotFree;
  assign homeGo    = inValid && slotFree;
  assign procRdata = lineData;
  assign freeIdx   = (hitState == LS_ABSENT) && !conflict;

  always_comb begin
    if (homeGo)         srcSel = SRC_HOME;
    else if (procValid) srcSel = SRC_PROC;
    else if (volValid)  srcSel = SRC_VOL;
    else                srcSel = SRC_NONE;
  end

  always_comb begin
    strobe     = '0;
    procRetire = 1'b0;
    procStall  = 1'b0;
    case (srcSel)
      SRC_HOME: begin
        procStall = procValid;
        case (inType)
          HM_FILL: if (hitState == LS_FILLPEND || freeIdx) begin
            strobe.wrEn = 1'b1; strobe.setTag = 1'b1; strobe.wrData = 1'b1;
            strobe.dataFromHome = 1'b1; strobe.newState = LS_CLEAN;
          end
          HM_WBACK: if (hitState == LS_WBPEND) begin
            strobe.wrEn = 1'b1; strobe.newState = LS_CLEAN;
          end
          HM_FLUSHACK: if (hitState == LS_WBPEND) begin
            strobe.wrEn = 1'b1; strobe.newState = LS_ABSENT;
          end
          default: begin
            if (hitState == LS_CLEAN) begin
              strobe.wrEn = 1'b1; strobe.newState = LS_ABSENT;
              strobe.sendEn = 1'b1; strobe.sendType = CM_PURGE;
            end else if (hitState == LS_DIRTY) begin
              strobe.wrEn = 1'b1; strobe.newState = LS_WBPEND;
              strobe.sendEn = 1'b1; strobe.sendType = CM_WB;
            end
          end
        endcase
      end
      SRC_PROC: begin
        case (hitState)
          LS_CLEAN, LS_DIRTY: begin
            case (procOp)
              OP_STORE: begin
                procRetire = 1'b1;
                strobe.wrEn = 1'b1; strobe.wrData = 1'b1; strobe.newState = LS_DIRTY;
              end
              OP_COMMIT: begin
                if (hitState == LS_CLEAN) procRetire = 1'b1;
                else begin
                  procStall = 1'b1;
                  if (slotFree) begin
                    strobe.wrEn = 1'b1; strobe.newState = LS_WBPEND;
                    strobe.sendEn = 1'b1; strobe.sendType = CM_WB;
                  end
                end
              end
              default: procRetire = 1'b1;
            endcase
          end
          LS_ABSENT: begin
            if (procOp == OP_LOAD || procOp == OP_STORE) begin
              procStall = 1'b1;
              if (slotFree && !conflict) begin
                strobe.wrEn = 1'b1; strobe.setTag = 1'b1; strobe.newState = LS_FILLPEND;
                strobe.sendEn = 1'b1; strobe.sendType = CM_FILLREQ;
              end
            end else begin
              procRetire = 1'b1;
            end
          end
          default: procStall = 1'b1;
        endcase
      end
      SRC_VOL: begin
        if (slotFree) begin
          case (volKind)
            VK_PURGE: if (hitState == LS_CLEAN) begin
              strobe.wrEn = 1'b1; strobe.newState = LS_ABSENT;
              strobe.sendEn = 1'b1; strobe.sendType = CM_PURGE;
            end
            VK_WRITEBACK: if (hitState == LS_DIRTY) begin
              strobe.wrEn = 1'b1; strobe.newState = LS_WBPEND;
              strobe.sendEn = 1'b1; strobe.sendType = CM_WB;
            end
            VK_PREFETCH: if (freeIdx) begin
              strobe.wrEn = 1'b1; strobe.setTag = 1'b1; strobe.newState = LS_FILLPEND;
              strobe.sendEn = 1'b1; strobe.sendType = CM_FILLREQ;
            end
            default: ;
          endcase
        end
      end
      default: ;
    endcase
  end

  AST_HOME_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && procValid) |-> (procStall && !procRetire)); // R12
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rstN)
    procValid |-> ($countones({procRetire, procStall}) == 1)); // R2
  AST_PENDING_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (procValid && !inValid && (hitState == LS_WBPEND || hitState == LS_FILLPEND)) |-> (procStall && !strobe.wrEn)); // R3
endmodule

// File: rtl/coh_cache_engine.sv
`timescale 1ns/1ps
module coh_cache_engine
  import coh_cache_engine_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procValid,
  input  logic [1:0]        procOp,
  input  logic [ADDR_W-1:0] procAddr,
  input  logic [DATA_W-1:0] procWdata,
  output logic              procRetire,
  output logic              procStall,
  output logic [DATA_W-1:0] procRdata,
  input  logic              inValid,
  output logic              inReady,
  input  logic [1:0]        inType,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  input  logic              volValid,
  input  logic [1:0]        volKind,
  input  logic [ADDR_W-1:0] volAddr,
  output logic              outValid,
  input  logic              outReady,
  output logic [1:0]        outType,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData
);
  src_e              srcSel;
  strobe_t           strobe;
  lineState_e        hitState;
  logic              conflict;
  logic [DATA_W-1:0] lineData;
  cacheMsg_e         outTypeE;

  assign outType = outTypeE;

  coh_cache_control #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .procValid(procValid), .procOp(procOp_e'(procOp)),
    .inValid(inValid), .inType(homeMsg_e'(inType)),
    .volValid(volValid), .volKind(volKind_e'(volKind)),
    .slotFree(!outValid), .hitState(hitState), .conflict(conflict), .lineData(lineData),
    .srcSel(srcSel), .strobe(strobe),
    .procRetire(procRetire), .procStall(procStall), .procRdata(procRdata), .inReady(inReady)
  );

  coh_cache_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_dp (
    .clk(clk), .rstN(rstN), .srcSel(srcSel),
    .procAddr(procAddr), .inAddr(inAddr), .volAddr(volAddr),
    .procWdata(procWdata), .inData(inData), .strobe(strobe),
    .hitState(hitState), .conflict(conflict), .lineData(lineData),
    .outReady(outReady), .outValid(outValid), .outType(outTypeE),
    .outAddr(outAddr), .outData(outData)
  );
endmodule

// File: tb/coh_cache_engine_tb.sv
`timescale 1ns/1ps
module coh_cache_engine_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [AW-1:0] A = 8'h10, B = 8'h20, C = 8'h05, D = 8'h06, E = 8'h07;

  logic clk = 1'b0, rstN = 1'b0;
  logic procValid = 0, inValid = 0, volValid = 0, outReady = 0;
  logic [1:0] procOp = 0, inType = 0, volKind = 0;
  logic [AW-1:0] procAddr = 0, inAddr = 0, volAddr = 0;
  logic [DW-1:0] procWdata = 0, inData = 0;
  logic procRetire, procStall, inReady, outValid;
  logic [DW-1:0] procRdata, outData;
  logic [1:0] outType;
  logic [AW-1:0] outAddr;
  int compared = 0, mismatched = 0;

  always #2 clk = ~clk;

  coh_cache_engine #(.ADDR_W(AW), .DATA_W(DW), .LINES(4)) u_dut (
    .clk(clk), .rstN(rstN), .procValid(procValid), .procOp(procOp), .procAddr(procAddr),
    .procWdata(procWdata), .procRetire(procRetire), .procStall(procStall), .procRdata(procRdata),
    .inValid(inValid), .inReady(inReady), .inType(inType), .inAddr(inAddr), .inData(inData),
    .volValid(volValid), .volKind(volKind), .volAddr(volAddr), .outValid(outValid),
    .outReady(outReady), .outType(outType), .outAddr(outAddr), .outData(outData));

  task automatic chkEq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    procValid = 0; inValid = 0; volValid = 0;
  endtask

  // op: 0 load, 1 store, 2 commit, 3 reconcile
  task automatic proc(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input bit expRetire, input bit chkData, input logic [DW-1:0] expData, input string req);
    @(negedge clk);
    procValid = 1; procOp = op; procAddr = a; procWdata = wd;
    #1;
    chkEq(req, "retire", procRetire, expRetire);
    chkEq(req, "stall", procStall, !expRetire);
    if (chkData) chkEq(req, "rdata", procRdata, expData);
    tick();
  endtask

  task automatic home(input logic [1:0] t, input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    @(negedge clk);
    inValid = 1; inType = t; inAddr = a; inData = d;
    #1 chkEq(req, "inReady", inReady, 1'b1);
    tick();
  endtask

  task automatic vol(input logic [1:0] k, input logic [AW-1:0] a);
    @(negedge clk);
    volValid = 1; volKind = k; volAddr = a;
    tick();
  endtask

  task automatic expectMsg(input logic [1:0] t, input logic [AW-1:0] a, input bit chkData,
                           input logic [DW-1:0] d, input string req);
    @(negedge clk); #1;
    chkEq(req, "outValid", outValid, 1'b1);
    chkEq(req, "outType", outType, t);
    chkEq(req, "outAddr", outAddr, a);
    if (chkData) chkEq(req, "outData", outData, d);
    outReady = 1;
    @(posedge clk); #1 outReady = 0;
  endtask

  task automatic expectNoMsg(input string req);
    @(negedge clk); #1 chkEq(req, "outValid idle", outValid, 1'b0);
  endtask

  task automatic testReset();
    @(negedge clk); #1;
    chkEq("R1", "outValid", outValid, 1'b0);
    chkEq("R1", "inReady", inReady, 1'b1);
    proc(0, C, 0, 0, 0, 0, "R1");           // absent line: load stalls
    expectMsg(0, C, 0, 0, "R1");            // fill request proves absent
    home(0, C, 16'h0C0C, "R7");
  endtask

  task automatic testMissAndFill();
    proc(0, A, 0, 0, 0, 0, "R4");
    expectMsg(0, A, 0, 0, "R4");
    proc(0, A, 0, 0, 0, 0, "R3");           // FillPending stalls
    proc(2, A, 0, 0, 0, 0, "R3");
    proc(3, A, 0, 0, 0, 0, "R6");
    expectNoMsg("R3");
    home(0, A, 16'h1234, "R7");
    proc(0, A, 0, 1, 1, 16'h1234, "R7");
    proc(2, A, 0, 1, 0, 0, "R5");           // clean commit retires
    proc(3, A, 0, 1, 0, 0, "R6");
  endtask

  task automatic testStoreCommit();
    proc(1, A, 16'hBEEF, 1, 0, 0, "R2");
    proc(0, A, 0, 1, 1, 16'hBEEF, "R2");
    proc(3, A, 0, 1, 0, 0, "R6");           // reconcile on Dirty
    proc(2, A, 0, 0, 0, 0, "R5");
    expectMsg(1, A, 1, 16'hBEEF, "R5");
    proc(0, A, 0, 0, 0, 0, "R3");           // WritebackPending stalls
    proc(3, A, 0, 0, 0, 0, "R6");
    home(1, A, 0, "R8");
    proc(0, A, 0, 1, 1, 16'hBEEF, "R8");
    proc(2, A, 0, 1, 0, 0, "R8");           // now Clean
    proc(1, A, 16'h1111, 1, 0, 0, "R2");
    proc(2, A, 0, 0, 0, 0, "R5");
    expectMsg(1, A, 1, 16'h1111, "R5");
    home(2, A, 0, "R8");                    // flush ack removes
    proc(0, A, 0, 0, 0, 0, "R8");
    expectMsg(0, A, 0, 0, "R8");
    home(0, A, 16'h2222, "R7");
    proc(0, A, 0, 1, 1, 16'h2222, "R7");
  endtask

  task automatic testConflict();
    proc(0, B, 0, 0, 0, 0, "R4");           // index held by A
    expectNoMsg("R4");
    proc(1, B, 16'h9999, 0, 0, 0, "R4");
    expectNoMsg("R4");
    proc(2, B, 0, 1, 0, 0, "R5");
    proc(3, B, 0, 1, 0, 0, "R6");
    proc(0, A, 0, 1, 1, 16'h2222, "R4");    // resident untouched
  endtask

  task automatic testPurgeReq();
    home(3, A, 0, "R9");
    expectMsg(2, A, 0, 0, "R9");
    proc(0, A, 0, 0, 0, 0, "R9");
    expectMsg(0, A, 0, 0, "R9");
    home(0, A, 16'h3333, "R7");
    proc(1, A, 16'h4444, 1, 0, 0, "R2");
    home(3, A, 0, "R9");
    expectMsg(1, A, 1, 16'h4444, "R9");
    proc(0, A, 0, 0, 0, 0, "R9");
    home(3, A, 0, "R9");                    // ignored while pending
    expectNoMsg("R9");
    home(1, A, 0, "R8");
    proc(0, A, 0, 1, 1, 16'h4444, "R9");
    home(3, D, 0, "R9");                    // absent: ignored
    expectNoMsg("R9");
  endtask

  task automatic testVoluntary();
    vol(0, A);
    expectMsg(2, A, 0, 0, "R10");
    proc(0, A, 0, 0, 0, 0, "R10");
    expectMsg(0, A, 0, 0, "R10");
    vol(1, C);                              // C is Clean: no effect
    expectNoMsg("R10");
    proc(1, C, 16'h6666, 1, 0, 0, "R2");
    vol(1, C);
    expectMsg(1, C, 1, 16'h6666, "R10");
    proc(0, C, 0, 0, 0, 0, "R10");
    home(1, C, 0, "R8");
    vol(2, D);
    expectMsg(0, D, 0, 0, "R10");
    home(0, D, 16'h5555, "R7");
    proc(0, D, 0, 1, 1, 16'h5555, "R10");
    vol(0, D);
    expectMsg(2, D, 0, 0, "R10");
  endtask

  task automatic testBusySlot();
    proc(1, C, 16'h7777, 1, 0, 0, "R2");
    proc(2, C, 0, 0, 0, 0, "R5");           // Wb queued, not taken
    @(negedge clk); #1 chkEq("R11", "inReady busy", inReady, 1'b0);
    proc(0, D, 0, 0, 0, 0, "R11");          // needs message, must not allocate
    proc(2, C, 0, 0, 0, 0, "R11");
    expectMsg(1, C, 1, 16'h7777, "R11");    // held unchanged
    proc(0, D, 0, 0, 0, 0, "R11");
    expectMsg(0, D, 0, 0, "R11");           // D was still absent
  endtask

  task automatic testPriority();
    @(negedge clk);
    inValid = 1; inType = 1; inAddr = C;
    procValid = 1; procOp = 3; procAddr = E;
    #1;
    chkEq("R12", "home wins stall", procStall, 1'b1);
    chkEq("R12", "home wins retire", procRetire, 1'b0);
    tick();
    proc(0, C, 0, 1, 1, 16'h7777, "R12");
    @(negedge clk);
    procValid = 1; procOp = 2; procAddr = C;
    volValid = 1; volKind = 0; volAddr = C;
    #1 chkEq("R12", "proc over vol retire", procRetire, 1'b1);
    tick();
    expectNoMsg("R12");
    proc(0, C, 0, 1, 1, 16'h7777, "R12");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testMissAndFill();
    testStoreCommit();
    testConflict();
    testPurgeReq();
    testVoluntary();
    testBusySlot();
    testPriority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule